// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side control for a synchronous burst read on a 16-bit memory port. A read starts when the address-valid strobe is high on a rising clock edge with chip enable active. That edge captures the start address and a snapshot of the configuration. The block then waits a programmable number of clock cycles. After that it presents one word per clock and steps the word address on each rising edge. A ready flag marks the cycles in which the presented word is valid, but only when the configuration enables it.

Two address orders are available. The continuous order climbs through the address space and spends one extra cycle, with ready low, each time it enters a new 64-word block. The wrap order stays inside the aligned 8-word group of the start address and wraps to the group's lowest word. Both orders run until chip enable drops or a new address is latched. A computed stand-in array supplies the data. Output drive is modelled by an output-enable flag rather than by tri-state pins.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration holds 7 wait cycles, continuous order and ready disabled, and `rdy` is low.
- R2: A rising edge with `chip_en` and `addr_vld` both high latches `addr_in` and abandons any burst in progress. The wait count restarts from the new address.
- R3: With a wait count N, the first word is presented in the N-th cycle after the latching edge, and `rdy` stays low before it. A written wait value below 2 is stored as 2.
- R4: In continuous order the address rises by one per clock. When the new address is a multiple of 64, one extra cycle is inserted with `rdy` low, so that word appears one cycle later.
- R5: In wrap order the low 3 address bits count modulo 8 while the upper bits hold. For example, a start at offset 6 gives offsets 6, 7, 0, 1, and so on, with no inserted cycles and no end.
- R6: `rdy` goes high only on valid-word cycles, and only when the ready-enable bit of the latched configuration is 1. With the bit at 0, `rdy` stays low and the words follow the same schedule.
- R7: A `cfg_we` pulse stores the wait count, the order select (`cfg_wrap`, 1 = wrap) and the ready enable. The stored values apply from the next address latch and leave a running burst unchanged.
- R8: The word presented for address A is A XOR 16'hA5C3.
- R9: `data_oe` is high exactly when `chip_en` and `out_en` are both high. Dropping `chip_en` ends the burst and forces `rdy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wait | input | 3 | Wait cycle count to store |
| cfg_wrap | input | 1 | Order select: 1 = 8-word wrap, 0 = continuous |
| cfg_rdy_en | input | 1 | Ready output enable to store |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| addr_vld | input | 1 | Address-valid strobe |
| addr_in | input | 16 | Start word address |
| data_out | output | 16 | Word at the current burst address |
| data_oe | output | 1 | Data drive flag (low models high impedance) |
| rdy | output | 1 | Valid-word flag |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-word wrap group, a 64-word stall boundary and a wait range of 2 to 7. Because the boundary is only 64 words, a short continuous burst started a few words below a multiple of 64 reaches the stall cycle within a handful of clocks. The 3-bit wait field lets the bench run both latency extremes, including the clamp of a written value of 1 up to 2. Starting a wrap burst at offset 6 near the top of a 64-word block shows that the wrap order never takes the stall.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned WAIT_W = 3;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_n;
        logic              wrap;
        logic              rdy_en;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{wait_n: 3'd7, wrap: 1'b0, rdy_en: 1'b0};

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_pkg::*;
#(
    parameter int unsigned WAIT_MIN = 2,
    parameter int unsigned WAIT_MAX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WAIT_W-1:0] wr_wait,
    input  logic              wr_wrap,
    input  logic              wr_rdy_en,
    output burst_cfg_t        cfg
);

    localparam logic [WAIT_W-1:0] LO = WAIT_W'(WAIT_MIN);
    localparam logic [WAIT_W-1:0] HI = WAIT_W'(WAIT_MAX);

    burst_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_wait < LO)      cfg_d.wait_n = LO;
            else if (wr_wait > HI) cfg_d.wait_n = HI;
            else                   cfg_d.wait_n = wr_wait;
            cfg_d.wrap   = wr_wrap;
            cfg_d.rdy_en = wr_rdy_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned GROUP_LG = 3,
    parameter int unsigned BOUND_LG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr_in,
    input  burst_cfg_t        cfg,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              word_valid,
    output logic              act_wrap,
    output logic              act_rdy_en
);

    typedef struct packed {
        logic              busy;
        logic              stall;
        logic [WAIT_W-1:0] cnt;
        logic [ADDR_W-1:0] addr;
        burst_cfg_t        act;
    } seq_t;

    localparam seq_t SEQ_RESET = '{busy: 1'b0, stall: 1'b0, cnt: '0, addr: '0, act: CFG_RESET};

    seq_t s_d, s_q;
    logic [ADDR_W-1:0] lin_next;
    logic [ADDR_W-1:0] wrap_next;
    logic              enter_block;

    assign lin_next    = s_q.addr + 1'b1;
    assign enter_block = (lin_next[BOUND_LG-1:0] == '0);

    generate
        if (GROUP_LG > 0) begin : g_wrap
            logic [GROUP_LG-1:0] low_next;
            assign low_next  = s_q.addr[GROUP_LG-1:0] + 1'b1;
            assign wrap_next = {s_q.addr[ADDR_W-1:GROUP_LG], low_next};
        end else begin : g_nowrap
            assign wrap_next = s_q.addr;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (!chip_en) begin
            s_d.busy  = 1'b0;
            s_d.stall = 1'b0;
        end else if (addr_vld) begin
            s_d.busy  = 1'b1;
            s_d.stall = 1'b0;
            s_d.cnt   = cfg.wait_n;
            s_d.addr  = addr_in;
            s_d.act   = cfg;
        end else if (s_q.busy) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else if (s_q.stall) begin
                s_d.stall = 1'b0;
            end else if (s_q.act.wrap) begin
                s_d.addr = wrap_next;
            end else begin
                s_d.addr  = lin_next;
                s_d.stall = enter_block;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RESET;
        else        s_q <= s_d;
    end

    assign cur_addr   = s_q.addr;
    assign word_valid = s_q.busy && (s_q.cnt == '0) && !s_q.stall;
    assign act_wrap   = s_q.act.wrap;
    assign act_rdy_en = s_q.act.rdy_en;

endmodule

// File: rtl/burst_word_src.sv
module burst_word_src #(
    parameter int unsigned           ADDR_W = 16,
    parameter int unsigned           DATA_W = 16,
    parameter logic [DATA_W-1:0]     SEED   = 16'hA5C3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign word[i] = addr[i % ADDR_W] ^ SEED[i];
        end
    endgenerate

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import burst_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter int unsigned       DATA_W   = 16,
    parameter int unsigned       GROUP_LG = 3,
    parameter int unsigned       BOUND_LG = 6,
    parameter int unsigned       WAIT_MIN = 2,
    parameter int unsigned       WAIT_MAX = 7,
    parameter logic [DATA_W-1:0] SEED     = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_wrap,
    input  logic              cfg_rdy_en,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy
);

    burst_cfg_t        cfg;
    logic [ADDR_W-1:0] cur_addr;
    logic              word_valid;
    logic              act_wrap;
    logic              act_rdy_en;

    burst_cfg_reg #(.WAIT_MIN(WAIT_MIN), .WAIT_MAX(WAIT_MAX)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_wait   (cfg_wait),
        .wr_wrap   (cfg_wrap),
        .wr_rdy_en (cfg_rdy_en),
        .cfg       (cfg)
    );

    burst_addr_seq #(.ADDR_W(ADDR_W), .GROUP_LG(GROUP_LG), .BOUND_LG(BOUND_LG)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .addr_vld   (addr_vld),
        .addr_in    (addr_in),
        .cfg        (cfg),
        .cur_addr   (cur_addr),
        .word_valid (word_valid),
        .act_wrap   (act_wrap),
        .act_rdy_en (act_rdy_en)
    );

    burst_word_src #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) u_src (
        .addr (cur_addr),
        .word (data_out)
    );

    assign data_oe = chip_en && out_en;
    assign rdy     = chip_en && word_valid && act_rdy_en;

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned GROUP_LG = 3,
    parameter int unsigned BOUND_LG = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              addr_vld,
    input logic              rdy,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              word_valid,
    input logic              act_wrap
);

    // R3: the wait count is at least 2, so no word right after a latch
    a_r3_wait_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && addr_vld) |=> !word_valid);

    // R3: nor one cycle after that
    a_r3_wait_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chip_en && addr_vld, 2) |-> !word_valid);

    // R4: continuous order climbs by one word
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !act_wrap && chip_en && !addr_vld)
        |=> ((cur_addr - $past(cur_addr)) == ADDR_W'(1)));

    // R4: entering a new block costs one cycle without a valid word
    a_r4_block_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !act_wrap && chip_en && !addr_vld && (cur_addr[BOUND_LG-1:0] == '1))
        |=> (!word_valid && !rdy));

    // R5: wrap order never leaves its group
    a_r5_wrap_group: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && act_wrap && chip_en && !addr_vld)
        |=> (word_valid && (cur_addr[ADDR_W-1:GROUP_LG] == $past(cur_addr[ADDR_W-1:GROUP_LG]))));

    // R9: dropping chip enable ends the burst
    a_r9_chip_disable_ends: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> !word_valid);

endmodule

bind burst_read_seq burst_read_seq_chk #(
    .ADDR_W(ADDR_W), .GROUP_LG(GROUP_LG), .BOUND_LG(BOUND_LG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .addr_vld   (addr_vld),
    .rdy        (rdy),
    .cur_addr   (cur_addr),
    .word_valid (word_valid),
    .act_wrap   (act_wrap)
);

// File: tb/tb_burst_read_seq.sv
`timescale 1ns/1ps
module tb_burst_read_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wait = 3'd0;
    logic        cfg_wrap = 1'b0;
    logic        cfg_rdy_en = 1'b0;
    logic        chip_en = 1'b0;
    logic        out_en = 1'b0;
    logic        addr_vld = 1'b0;
    logic [15:0] addr_in = 16'h0;
    logic [15:0] data_out;
    logic        data_oe;
    logic        rdy;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int wd = 0;

    typedef struct {
        int          cyc;
        logic [15:0] data;
        bit          rdy;
        int          rdy_req;
        int          gap_req;
        int          data_req;
    } item_t;

    item_t q[$];

    always #2 clk = ~clk;

    burst_read_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wait(cfg_wait),
        .cfg_wrap(cfg_wrap), .cfg_rdy_en(cfg_rdy_en), .chip_en(chip_en),
        .out_en(out_en), .addr_vld(addr_vld), .addr_in(addr_in),
        .data_out(data_out), .data_oe(data_oe), .rdy(rdy)
    );

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Monitor: cycle index since the latching edge, scoreboard pop and compare
    always @(clk) begin
        if (clk) begin
            if (rst_n && chip_en && addr_vld) cyc = -1;
        end else if (rst_n) begin
            cyc++;
            if (q.size() > 0) begin
                if (q[0].cyc == cyc) begin
                    item_t h;
                    h = q.pop_front();
                    chk(data_out == h.data, h.data_req, "word", 32'(data_out), 32'(h.data));
                    chk(rdy == h.rdy, h.rdy_req, "ready on word", 32'(rdy), 32'(h.rdy));
                end else begin
                    chk(rdy == 1'b0, q[0].gap_req, "ready low between words", 32'(rdy), 32'd0);
                end
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic cfg_write(input logic [2:0] w, input bit wrap, input bit re);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_wait = w; cfg_wrap = wrap; cfg_rdy_en = re;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Driver: flush the scoreboard, push the expected words, pulse the strobe
    task automatic start_burst(input logic [15:0] a0, input int n, input int wait_n,
                               input bit wrap, input bit re, input int rdy_req,
                               input int data_req);
        logic [15:0] a;
        int c;
        @(negedge clk); #1;
        q.delete();
        a = a0;
        c = wait_n;
        for (int i = 0; i < n; i++) begin
            item_t it;
            int gap;
            gap = 3;                       // R3 wait before the first word
            if (i > 0) begin
                c++;
                gap = 5;
                if (wrap) begin
                    a[2:0] = a[2:0] + 3'd1;
                end else begin
                    a = a + 16'd1;
                    gap = 4;
                    if (a[5:0] == 6'd0) c++;   // R4 boundary stall cycle
                end
            end
            it.cyc = c;
            it.data = a ^ 16'hA5C3;            // R8 stand-in array
            it.rdy = re;
            it.rdy_req = rdy_req;
            it.gap_req = gap;
            it.data_req = data_req;
            q.push_back(it);
        end
        addr_in = a0;
        addr_vld = 1'b1;
        @(negedge clk); #1;
        addr_vld = 1'b0;
    endtask

    task automatic drain;
        while (q.size() != 0) @(negedge clk);
        #1 chip_en = 1'b0;
        @(negedge clk);
        chk(rdy == 1'b0, 9, "ready after chip disable", 32'(rdy), 32'd0);   // R9
        #1 chip_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(rdy == 1'b0, 1, "ready in reset", 32'(rdy), 32'd0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b0, 1, "ready after reset", 32'(rdy), 32'd0);
        chk(data_oe == 1'b0, 9, "drive flag, chip off", 32'(data_oe), 32'd0);   // R9
        #1 chip_en = 1'b1; out_en = 1'b0;
        @(negedge clk);
        chk(data_oe == 1'b0, 9, "drive flag, output off", 32'(data_oe), 32'd0);
        #1 out_en = 1'b1;
        @(negedge clk);
        chk(data_oe == 1'b1, 9, "drive flag, both on", 32'(data_oe), 32'd1);

        // R1 and R6: reset config gives 7 waits, continuous order, ready off
        start_burst(16'h0010, 6, 7, 1'b0, 1'b0, 1, 8);
        drain();

        // R3 shortest wait, R4 crossing the block at 0x0140
        cfg_write(3'd2, 1'b0, 1'b1);
        start_burst(16'h013C, 10, 2, 1'b0, 1'b1, 3, 4);
        drain();

        // R5 wrap from offset 6 with ready on (R6)
        cfg_write(3'd5, 1'b1, 1'b1);
        start_burst(16'h0206, 12, 5, 1'b1, 1'b1, 6, 5);
        drain();

        // R3 clamp of a written 1 to 2; R5 wrap at the top of a block, no stall
        cfg_write(3'd1, 1'b1, 1'b1);
        start_burst(16'h03FE, 10, 2, 1'b1, 1'b1, 3, 5);
        drain();

        // R2: a new strobe abandons the running burst
        cfg_write(3'd4, 1'b0, 1'b1);
        start_burst(16'h0500, 20, 4, 1'b0, 1'b1, 2, 2);
        repeat (6) @(negedge clk);
        start_burst(16'h0600, 5, 4, 1'b0, 1'b1, 2, 2);
        drain();

        // R7: a write during a burst leaves it unchanged, applies at next latch
        cfg_write(3'd3, 1'b0, 1'b1);
        start_burst(16'h0700, 8, 3, 1'b0, 1'b1, 7, 7);
        repeat (2) @(negedge clk);
        cfg_write(3'd6, 1'b1, 1'b0);
        drain();
        start_burst(16'h0805, 9, 6, 1'b1, 1'b0, 7, 7);
        drain();

        summary();
        $finish;
    end

endmodule